// File: doc/BRIEF.md
# Least-Laxity Task Dispatcher

This block is the dispatch engine for a cluster of processing elements. It holds a fixed pool of task slots. Each slot records a task identifier, a real-time flag, an absolute deadline, the remaining worst-case execution time, the processing-element type the task needs, and a lifecycle state. Software or a dependency engine loads a task into a free slot. It marks the task configured once its code and data are in place. From then on the dispatcher decides where and when the task runs.

On each scheduling tick the dispatcher computes the slack of every real-time task from a free-running tick counter: deadline minus current time minus remaining execution time. It ranks the tasks and fills idle processing elements of the right type with the most urgent work. Non-real-time work fills whatever capacity is left, shortest job first. When no matching element is idle, a more urgent real-time task displaces the least urgent running task on a matching element. The displaced task returns to the ready pool and keeps its remaining execution time, so it may later resume on any element of its type. Commands go out as one-cycle pulses, one per element at most, each carrying the identifier of the task to start.

Top module: `llf_sched_top`

## Requirements
- R1: After reset no execute or preempt command is issued, and the deadline-miss output is low.
- R2: A loaded task is never dispatched until its configuration-complete strobe has been received; after that it is eligible from the next tick on.
- R3: Laxity is deadline minus the tick count minus remaining execution time. On a tick, idle elements are filled in ascending element index, each taking the smallest-laxity ready task, so the lower-numbered idle element receives the more urgent task.
- R4: A task is only ever issued to an element whose reported type equals the task's type field.
- R5: Between ready real-time tasks of equal laxity, the one with the earlier deadline is issued first, regardless of slot index; with equal laxity and deadline, the lower slot index wins.
- R6: A non-real-time task is issued to an idle element only when no ready real-time task of that element's type remains unassigned in that tick; among non-real-time tasks the smallest remaining execution time goes first.
- R7: When a ready real-time task has no idle matching element and is strictly more urgent than the least urgent task running on a matching element, that element receives a preempt command carrying the incoming task identifier. A running non-real-time task ranks below every real-time task. At most one preemption occurs per tick.
- R8: A preempted task returns to the ready pool with its remaining execution time preserved and may later be issued to any element of its type.
- R9: A completion report frees the slot and the element. The freed element can receive a command from the next tick on. An element that reports completion in the same cycle as a tick receives neither an execute nor a preempt command from that tick.
- R10: An element reporting busy receives no command.
- R11: On each tick the deadline-miss output is set high exactly when some ready or running real-time task has negative laxity at that tick; between ticks it holds.
- R12: No element receives an execute and a preempt command in the same cycle.
- R13: Commands are single-cycle pulses in the cycle after a tick. A running task's remaining execution time drops by one on every tick it spends running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Scheduling tick strobe; advances the time counter |
| load_valid | input | 1 | Load a task into a free slot |
| load_slot | input | SLOT_W | Slot index to load |
| load_tid | input | TID_W | Task identifier |
| load_rt | input | 1 | 1 = real-time task, 0 = non-real-time |
| load_deadline | input | TIME_W | Absolute deadline in ticks |
| load_wcet | input | TIME_W | Worst-case execution time in ticks |
| load_type | input | TYPE_W | Required processing-element type |
| cfg_valid | input | 1 | Configuration complete for a loaded slot |
| cfg_slot | input | SLOT_W | Slot whose configuration completed |
| pe_type | input | NUM_PE*TYPE_W | Type of each element, element 0 in the low bits |
| pe_busy | input | NUM_PE | Element cannot accept a command |
| pe_done | input | NUM_PE | Element finished its task (pulse) |
| cmd_exec | output | NUM_PE | Execute command pulse per element |
| cmd_preempt | output | NUM_PE | Preempt-and-execute command pulse per element |
| cmd_tid | output | NUM_PE*TID_W | Task identifier for each element's command |
| deadline_miss | output | 1 | Some real-time task had negative laxity at the last tick |

## Verification
Completion reports and scheduling ticks can land in the same cycle. A finishing task may be the least urgent one running, which makes its element the natural preemption victim. The bench drives a completion pulse together with a tick while an urgent real-time task waits. It expects no command at all from that tick, then an execute command to the freed element on the following tick. Slack values for every checked tick are worked out by hand from the loaded deadlines, the tick count and the per-tick decrement of running tasks.

// File: rtl/llf_sched_pkg.sv
// Shared widths, slot lifecycle type and laxity arithmetic for the
// least-laxity dispatcher. Assumes deadlines do not wrap within a run.
package llf_sched_pkg;
    localparam int TIME_W = 16;
    localparam int TID_W  = 8;
    localparam int TYPE_W = 2;
    localparam int LAX_W  = TIME_W + 2;
    localparam int KEY_W  = 1 + LAX_W + TIME_W;

    typedef enum logic [1:0] {
        SLOT_FREE,
        SLOT_LOADED,
        SLOT_READY,
        SLOT_RUN
    } slot_state_e;

    typedef logic [KEY_W-1:0] key_t;

    // Signed slack: deadline - now - remaining
    function automatic logic signed [LAX_W-1:0] calc_laxity(
        input logic [TIME_W-1:0] dl,
        input logic [TIME_W-1:0] now,
        input logic [TIME_W-1:0] rem
    );
        return $signed({2'b00, dl}) - $signed({2'b00, now}) - $signed({2'b00, rem});
    endfunction
endpackage

// File: rtl/llf_slot_key.sv
// Builds one slot's unsigned ranking key: smaller means more urgent.
// Real-time tasks order by laxity then deadline; non-real-time tasks
// always rank below them and order by remaining execution time.
module llf_slot_key
    import llf_sched_pkg::*;
(
    input  logic              rt,
    input  logic [TIME_W-1:0] deadline,
    input  logic [TIME_W-1:0] remaining,
    input  logic [TIME_W-1:0] now,
    output key_t              key,
    output logic              late
);
    logic signed [LAX_W-1:0] lax;

    // Compute slack, lateness and the packed key
    always_comb begin
        lax  = calc_laxity(deadline, now, remaining);
        late = rt && lax[LAX_W-1];
        if (rt)
            key = {1'b0, ~lax[LAX_W-1], lax[LAX_W-2:0], deadline};
        else
            key = {1'b1, 2'b00, remaining, {TIME_W{1'b0}}};
    end
endmodule

// File: rtl/llf_dispatch_chain.sv
// Greedy fill of idle elements in ascending element index. Each idle
// element takes the lowest-key ready task of its type not already taken
// this tick; non-real-time tasks qualify only when no real-time task of
// that type is left. Ties resolve to the lowest slot index.
module llf_dispatch_chain
    import llf_sched_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int NUM_PE    = 8,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS-1:0] ready,
    input  logic [NUM_SLOTS-1:0] rt,
    input  key_t                 key       [NUM_SLOTS],
    input  logic [TYPE_W-1:0]    stype     [NUM_SLOTS],
    input  logic [NUM_PE-1:0]    pe_free,
    input  logic [TYPE_W-1:0]    pe_type   [NUM_PE],
    output logic [NUM_PE-1:0]    disp_valid,
    output logic [SLOT_W-1:0]    disp_slot [NUM_PE],
    output logic [NUM_SLOTS-1:0] taken
);
    logic              rt_left;
    logic              found;
    key_t              best;
    logic [SLOT_W-1:0] sel;

    // Walk elements in order, selecting and reserving one task each
    always_comb begin
        taken   = '0;
        rt_left = 1'b0;
        found   = 1'b0;
        best    = '1;
        sel     = '0;
        for (int p = 0; p < NUM_PE; p++) begin
            disp_valid[p] = 1'b0;
            disp_slot[p]  = '0;
            if (pe_free[p]) begin
                rt_left = 1'b0;
                for (int s = 0; s < NUM_SLOTS; s++)
                    if (ready[s] && !taken[s] && rt[s] && stype[s] == pe_type[p])
                        rt_left = 1'b1;
                found = 1'b0;
                best  = '1;
                sel   = '0;
                for (int s = 0; s < NUM_SLOTS; s++)
                    if (ready[s] && !taken[s] && stype[s] == pe_type[p] &&
                        (rt[s] || !rt_left) && (!found || key[s] < best)) begin
                        found = 1'b1;
                        best  = key[s];
                        sel   = SLOT_W'(s);
                    end
                if (found) begin
                    disp_valid[p] = 1'b1;
                    disp_slot[p]  = sel;
                    taken[sel]    = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/llf_preempt_pick.sv
// Picks at most one preemption per tick: the most urgent leftover
// real-time task against the least urgent running task on an eligible
// element of matching type. Fires only on strictly higher urgency.
module llf_preempt_pick
    import llf_sched_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int NUM_PE    = 8,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int PE_W     = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
    input  logic [NUM_SLOTS-1:0] cand,
    input  key_t                 key     [NUM_SLOTS],
    input  logic [TYPE_W-1:0]    stype   [NUM_SLOTS],
    input  logic [NUM_PE-1:0]    victim_ok,
    input  logic [SLOT_W-1:0]    pe_slot [NUM_PE],
    input  logic [TYPE_W-1:0]    pe_type [NUM_PE],
    output logic                 pre_valid,
    output logic [PE_W-1:0]      pre_pe,
    output logic [SLOT_W-1:0]    pre_slot
);
    logic c_found, v_found;
    key_t c_key, v_key;

    // Best candidate, then worst matching victim, then compare
    always_comb begin
        c_found  = 1'b0;
        c_key    = '1;
        pre_slot = '0;
        for (int s = 0; s < NUM_SLOTS; s++)
            if (cand[s] && (!c_found || key[s] < c_key)) begin
                c_found  = 1'b1;
                c_key    = key[s];
                pre_slot = SLOT_W'(s);
            end
        v_found = 1'b0;
        v_key   = '0;
        pre_pe  = '0;
        for (int p = 0; p < NUM_PE; p++)
            if (victim_ok[p] && pe_type[p] == stype[pre_slot] &&
                (!v_found || key[pe_slot[p]] > v_key)) begin
                v_found = 1'b1;
                v_key   = key[pe_slot[p]];
                pre_pe  = PE_W'(p);
            end
        pre_valid = c_found && v_found && (v_key > c_key);
    end
endmodule

// File: rtl/llf_sched_top.sv
// Least-laxity dispatcher top: slot pool, element occupancy, tick
// counter and registered command outputs. Assumes the element reports
// completion only for the task it was last commanded to run.
module llf_sched_top
    import llf_sched_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int NUM_PE    = 8,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int PE_W     = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic                     load_valid,
    input  logic [SLOT_W-1:0]        load_slot,
    input  logic [TID_W-1:0]         load_tid,
    input  logic                     load_rt,
    input  logic [TIME_W-1:0]        load_deadline,
    input  logic [TIME_W-1:0]        load_wcet,
    input  logic [TYPE_W-1:0]        load_type,
    input  logic                     cfg_valid,
    input  logic [SLOT_W-1:0]        cfg_slot,
    input  logic [NUM_PE*TYPE_W-1:0] pe_type,
    input  logic [NUM_PE-1:0]        pe_busy,
    input  logic [NUM_PE-1:0]        pe_done,
    output logic [NUM_PE-1:0]        cmd_exec,
    output logic [NUM_PE-1:0]        cmd_preempt,
    output logic [NUM_PE*TID_W-1:0]  cmd_tid,
    output logic                     deadline_miss
);
    slot_state_e          st     [NUM_SLOTS];
    logic [TID_W-1:0]     tid    [NUM_SLOTS];
    logic [TIME_W-1:0]    dl     [NUM_SLOTS];
    logic [TIME_W-1:0]    remain [NUM_SLOTS];
    logic [TYPE_W-1:0]    stype  [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] rt_f;
    key_t                 key    [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] late, ready, running, taken;
    logic [NUM_SLOTS-1:0] slot_go, slot_fin, slot_back;
    logic [TIME_W-1:0]    now;
    logic [NUM_PE-1:0]    pe_occ, disp_valid;
    logic [SLOT_W-1:0]    pe_slot   [NUM_PE];
    logic [SLOT_W-1:0]    disp_slot [NUM_PE];
    logic [TYPE_W-1:0]    pe_type_a [NUM_PE];
    logic                 pre_valid;
    logic [PE_W-1:0]      pre_pe;
    logic [SLOT_W-1:0]    pre_slot;

    for (genvar p = 0; p < NUM_PE; p++) begin : g_pe_type
        assign pe_type_a[p] = pe_type[p*TYPE_W +: TYPE_W];
    end

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_key
        assign ready[s]   = (st[s] == SLOT_READY);
        assign running[s] = (st[s] == SLOT_RUN);
        llf_slot_key u_key (
            .rt(rt_f[s]), .deadline(dl[s]), .remaining(remain[s]),
            .now(now), .key(key[s]), .late(late[s])
        );
    end

    llf_dispatch_chain #(.NUM_SLOTS(NUM_SLOTS), .NUM_PE(NUM_PE)) u_chain (
        .ready(ready), .rt(rt_f), .key(key), .stype(stype),
        .pe_free(~pe_occ & ~pe_busy), .pe_type(pe_type_a),
        .disp_valid(disp_valid), .disp_slot(disp_slot), .taken(taken)
    );

    llf_preempt_pick #(.NUM_SLOTS(NUM_SLOTS), .NUM_PE(NUM_PE)) u_pre (
        .cand(ready & rt_f & ~taken), .key(key), .stype(stype),
        .victim_ok(pe_occ & ~pe_busy & ~pe_done), .pe_slot(pe_slot),
        .pe_type(pe_type_a), .pre_valid(pre_valid), .pre_pe(pre_pe),
        .pre_slot(pre_slot)
    );

    // Per-slot start, finish and return-to-ready events
    always_comb begin
        slot_go   = '0;
        slot_fin  = '0;
        slot_back = '0;
        for (int p = 0; p < NUM_PE; p++) begin
            if (disp_valid[p]) slot_go[disp_slot[p]] = 1'b1;
            if (pe_occ[p] && pe_done[p]) slot_fin[pe_slot[p]] = 1'b1;
        end
        if (pre_valid) begin
            slot_go[pre_slot]        = 1'b1;
            slot_back[pe_slot[pre_pe]] = 1'b1;
        end
    end

    // Slot lifecycle: load, configure, run, finish, preempt, decrement
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SLOTS; s++) begin
                st[s]     <= SLOT_FREE;
                tid[s]    <= '0;
                dl[s]     <= '0;
                remain[s] <= '0;
                stype[s]  <= '0;
                rt_f[s]   <= 1'b0;
            end
        end else begin
            for (int s = 0; s < NUM_SLOTS; s++) begin
                case (st[s])
                    SLOT_FREE: if (load_valid && load_slot == SLOT_W'(s)) begin
                        st[s]     <= SLOT_LOADED;
                        tid[s]    <= load_tid;
                        dl[s]     <= load_deadline;
                        remain[s] <= load_wcet;
                        stype[s]  <= load_type;
                        rt_f[s]   <= load_rt;
                    end
                    SLOT_LOADED: if (cfg_valid && cfg_slot == SLOT_W'(s))
                        st[s] <= SLOT_READY;
                    SLOT_READY: if (tick && slot_go[s])
                        st[s] <= SLOT_RUN;
                    default: if (slot_fin[s]) begin
                        st[s] <= SLOT_FREE;
                    end else if (tick) begin
                        if (remain[s] != '0) remain[s] <= remain[s] - TIME_W'(1);
                        if (slot_back[s]) st[s] <= SLOT_READY;
                    end
                endcase
            end
        end
    end

    // Element occupancy and the slot bound to each element
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pe_occ <= '0;
            for (int p = 0; p < NUM_PE; p++) pe_slot[p] <= '0;
        end else begin
            for (int p = 0; p < NUM_PE; p++) begin
                if (pe_occ[p] && pe_done[p]) pe_occ[p] <= 1'b0;
                if (tick && disp_valid[p]) begin
                    pe_occ[p]  <= 1'b1;
                    pe_slot[p] <= disp_slot[p];
                end
                if (tick && pre_valid && pre_pe == PE_W'(p))
                    pe_slot[p] <= pre_slot;
            end
        end
    end

    // Tick counter, miss flag and one-cycle command outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now           <= '0;
            deadline_miss <= 1'b0;
            cmd_exec      <= '0;
            cmd_preempt   <= '0;
            cmd_tid       <= '0;
        end else begin
            if (tick) begin
                now           <= now + TIME_W'(1);
                deadline_miss <= |(late & (ready | running));
            end
            for (int p = 0; p < NUM_PE; p++) begin
                cmd_exec[p]    <= tick && disp_valid[p];
                cmd_preempt[p] <= tick && pre_valid && pre_pe == PE_W'(p);
                if (tick && disp_valid[p])
                    cmd_tid[p*TID_W +: TID_W] <= tid[disp_slot[p]];
                else if (tick && pre_valid && pre_pe == PE_W'(p))
                    cmd_tid[p*TID_W +: TID_W] <= tid[pre_slot];
                else
                    cmd_tid[p*TID_W +: TID_W] <= '0;
            end
        end
    end
endmodule

// File: rtl/llf_sched_chk.sv
// Port-level temporal checks for the dispatcher, bound into every
// instance of the top module.
module llf_sched_chk #(
    parameter int NUM_PE = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic [NUM_PE-1:0] pe_busy,
    input logic [NUM_PE-1:0] pe_done,
    input logic [NUM_PE-1:0] cmd_exec,
    input logic [NUM_PE-1:0] cmd_preempt,
    input logic              deadline_miss
);
    // R12: never two command kinds on one element
    a_r12_single_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_exec & cmd_preempt) == '0);

    // R13: commands only follow a tick
    a_r13_cmd_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> (cmd_exec | cmd_preempt) == '0);

    // R10: a busy element is left alone
    a_r10_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> ((cmd_exec | cmd_preempt) & $past(pe_busy)) == '0);

    // R9: an element finishing during a tick gets nothing from it
    a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> ((cmd_exec | cmd_preempt) & $past(pe_done)) == '0);

    // R11: miss flag only moves on a tick
    a_r11_miss_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(deadline_miss));
endmodule

bind llf_sched_top llf_sched_chk #(.NUM_PE(NUM_PE)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pe_busy(pe_busy),
    .pe_done(pe_done), .cmd_exec(cmd_exec), .cmd_preempt(cmd_preempt),
    .deadline_miss(deadline_miss)
);

// File: tb/llf_sched_top_tb.sv
`timescale 1ns/1ps
// Directed scenario bench: 8 slots, 4 elements (0,1 type 0; 2,3 type 1).
// Expected commands come from hand-derived laxities per tick.
module llf_sched_top_tb;
    import llf_sched_pkg::*;
    localparam int NS = 8;
    localparam int NP = 4;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
    logic load_valid = 1'b0, load_rt = 1'b0, cfg_valid = 1'b0;
    logic [2:0] load_slot = '0, cfg_slot = '0;
    logic [TID_W-1:0] load_tid = '0;
    logic [TIME_W-1:0] load_deadline = '0, load_wcet = '0;
    logic [TYPE_W-1:0] load_type = '0;
    logic [NP*TYPE_W-1:0] pe_type = {2'd1, 2'd1, 2'd0, 2'd0};
    logic [NP-1:0] pe_busy = '0, pe_done = '0;
    logic [NP-1:0] cmd_exec, cmd_preempt;
    logic [NP*TID_W-1:0] cmd_tid;
    logic deadline_miss;
    int checks = 0, fails = 0;

    always #2 clk = ~clk;

    llf_sched_top #(.NUM_SLOTS(NS), .NUM_PE(NP)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load_valid(load_valid),
        .load_slot(load_slot), .load_tid(load_tid), .load_rt(load_rt),
        .load_deadline(load_deadline), .load_wcet(load_wcet),
        .load_type(load_type), .cfg_valid(cfg_valid), .cfg_slot(cfg_slot),
        .pe_type(pe_type), .pe_busy(pe_busy), .pe_done(pe_done),
        .cmd_exec(cmd_exec), .cmd_preempt(cmd_preempt), .cmd_tid(cmd_tid),
        .deadline_miss(deadline_miss)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_cmd(input string req, input int ex, input int pr);
        chk({req, " exec"}, int'(cmd_exec), ex);
        chk({req, " preempt"}, int'(cmd_preempt), pr);
    endtask

    task automatic chk_tid(input string req, input int pe, input int exp);
        chk({req, " tid"}, int'(cmd_tid[pe*TID_W +: TID_W]), exp);
    endtask

    task automatic load(input int s, input int id, input int rt, input int d, input int w, input int ty);
        @(negedge clk);
        load_valid = 1'b1; load_slot = 3'(s); load_tid = TID_W'(id); load_rt = rt[0];
        load_deadline = TIME_W'(d); load_wcet = TIME_W'(w); load_type = TYPE_W'(ty);
        @(negedge clk);
        load_valid = 1'b0;
    endtask

    task automatic cfg(input int s);
        @(negedge clk); cfg_valid = 1'b1; cfg_slot = 3'(s);
        @(negedge clk); cfg_valid = 1'b0;
    endtask

    task automatic done(input int m);
        @(negedge clk); pe_done = NP'(m);
        @(negedge clk); pe_done = '0;
    endtask

    // Tick with optional simultaneous completion; sample after the edge
    task automatic tick_with(input int m);
        @(negedge clk); tick = 1'b1; pe_done = NP'(m);
        @(negedge clk); tick = 1'b0; pe_done = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_cmd("R1 reset", 0, 0);
        chk("R1 miss", int'(deadline_miss), 0);

        // now=0: slot0 unconfigured (lax 15); slot1 lax 40, slot2 lax 55, slot3 type1 lax 25
        load(0, 'h10, 1, 20, 5, 0);
        load(1, 'h11, 1, 50, 10, 0);
        load(2, 'h12, 1, 60, 5, 0);
        load(3, 'h13, 1, 30, 5, 1);
        cfg(1); cfg(2); cfg(3);
        tick_with(0);
        chk_cmd("R3 first fill", 'b0111, 0);
        chk_tid("R3 most urgent to PE0", 0, 'h11);
        chk_tid("R2 unconfigured slot skipped", 1, 'h12);
        chk_tid("R4 type1 task on type1 element", 2, 'h13);

        // now=1: slot0 lax 14 beats slot2 (lax 54) on PE1
        cfg(0);
        tick_with(0);
        chk_cmd("R7 preempt least urgent", 0, 'b0010);
        chk_tid("R7 incoming id", 1, 'h10);
        @(negedge clk);
        chk_cmd("R13 pulse ends", 0, 0);

        // now=2: PE0 freed, slot2 resumes there with remaining 4
        done('b0001);
        tick_with(0);
        chk_cmd("R8 migration", 'b0001, 0);
        chk_tid("R8 migrated id", 0, 'h12);

        // now=3: slot4 and slot5 both lax 27; slot5 deadline 35 wins
        load(4, 'h20, 1, 40, 10, 1);
        load(5, 'h21, 1, 35, 5, 1);
        cfg(4); cfg(5);
        tick_with(0);
        chk_cmd("R5 tie by deadline", 'b1000, 0);
        chk_tid("R5 earlier deadline", 3, 'h21);

        // now=4: type1 freed; RT slot4 first, then shortest NRT
        done('b1100);
        load(1, 'h30, 0, 0, 20, 1);
        load(3, 'h31, 0, 0, 7, 1);
        cfg(1); cfg(3);
        tick_with(0);
        chk_cmd("R6 rt before nrt", 'b1100, 0);
        chk_tid("R6 rt on PE2", 2, 'h20);
        chk_tid("R6 shortest nrt", 3, 'h31);

        // now=5: any RT displaces running NRT on PE3
        load(5, 'h40, 1, 200, 10, 1);
        cfg(5);
        tick_with(0);
        chk_cmd("R7 rt over nrt", 0, 'b1000);
        chk_tid("R7 incoming id", 3, 'h40);
        chk("R11 no miss yet", int'(deadline_miss), 0);

        // now=6: slot6 lax 5-6-3 = -4 -> miss; preempts PE0 (lax 53)
        load(6, 'h50, 1, 5, 3, 0);
        cfg(6);
        chk("R11 miss holds between ticks", int'(deadline_miss), 0);
        tick_with(0);
        chk("R11 miss raised", int'(deadline_miss), 1);
        chk_cmd("R7 preempt PE0", 0, 'b0001);
        chk_tid("R7 incoming id", 0, 'h50);

        // now=7: slot7 lax 3; PE1 (lax 13) finishes in the tick cycle
        load(7, 'h60, 1, 12, 2, 0);
        cfg(7);
        tick_with('b0010);
        chk_cmd("R9 finishing element untouched", 0, 0);
        chk("R11 miss still set", int'(deadline_miss), 1);

        // now=8: freed PE1 takes slot7
        tick_with(0);
        chk_cmd("R9 freed element reused", 'b0010, 0);
        chk_tid("R9 id", 1, 'h60);

        // now=9: PE0 freed but busy
        done('b0001);
        pe_busy = 'b0001;
        tick_with(0);
        chk_cmd("R10 busy element", 0, 0);
        chk("R11 miss cleared", int'(deadline_miss), 0);

        // now=10: PE0 available again, slot2 migrates back
        pe_busy = '0;
        tick_with(0);
        chk_cmd("R10 after busy", 'b0001, 0);
        chk_tid("R8 remaining kept", 0, 'h12);

        // now=11: type1 freed, NRT remaining 6 before 20
        done('b1100);
        tick_with(0);
        chk_cmd("R6 nrt fill", 'b1100, 0);
        chk_tid("R6 shorter first", 2, 'h31);
        chk_tid("R6 longer second", 3, 'h30);
        @(negedge clk);
        chk_cmd("R13 pulse ends", 0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule